// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block turns interrupt requests for a small 8-bit controller core into vectored jumps. It keeps a bitmask of hardware sources that are waiting, plus a separate reset request flag. A request pulse on any line sets the matching flag. The flag stays set until the block serves it.

When the core's global interrupt enable is high and something is waiting, the block accepts one request. It captures the current program counter and stack pointer. It then writes the return address to a byte-wide stack through a data-memory write port, one byte per clock. In its final cycle it presents the new program counter with a load strobe and a strobe that tells the core to clear its global enable.

The core stalls while `busy` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: Among the waiting hardware sources, the one with the lowest set bit index is served first. Source index i jumps to vector number i+1.
- R2: Accepting a hardware source clears only that source's bit in `pending`. All other bits keep their value.
- R3: No request is accepted while `gie_in` is low. Waiting requests stay in `pending` and `busy` stays low.
- R4: The reset request takes vector number 0 and has priority over hardware sources waiting in the same cycle. A reset entry leaves `pending` unchanged.
- R5: The new program counter is vector number times the slot size. The slot is 2 words when `LONG_JUMP` is 1 and 1 word when it is 0.
- R6: The return address is written as exactly `PC_BYTES` bytes (1, 2 or 3), least significant byte first.
- R7: The first stack byte is written at the captured `sp_in`. Each later byte goes one address lower, wrapping modulo 2^16. The final `sp_out` is `sp_in` minus `PC_BYTES`.
- R8: `gie_clr` pulses for one cycle together with `pc_load`, at the end of every entry.
- R9: `busy` rises in the cycle after acceptance. The write port is active on the next `PC_BYTES` cycles. `pc_load` follows as a single cycle, and `busy` falls after it.
- R10: Requests that arrive while `busy` is high are recorded in `pending` and served only after `busy` falls.
- R11: After reset, `busy`, `mem_we`, `pc_load`, `gie_clr` and `pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_req | input | NUM_SRC | One-cycle request pulses, one per hardware source |
| rst_req | input | 1 | One-cycle reset-entry request pulse |
| gie_in | input | 1 | Core's global interrupt enable |
| pc_in | input | PC_W | Current program counter (word address) |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | 16 | Stack byte write address |
| mem_wdata | output | 8 | Stack byte write data |
| pc_load | output | 1 | Load `pc_out` and `sp_out` into the core |
| pc_out | output | PC_W | Vector target program counter |
| sp_out | output | 16 | Stack pointer after the pushes |
| gie_clr | output | 1 | Clear the core's global interrupt enable |
| pending | output | NUM_SRC | Hardware sources currently waiting |

## Verification
Three instances with 3-, 2- and 1-byte program counters and both slot sizes get the same stimulus. This separates the vector arithmetic from the push length and the byte order. Some patterns hold the enable low while requests collect, and then raise it. Others pair a reset request with a hardware request in the same cycle, or add new requests during an entry. These show apart priority order, single-bit clearing and latching while busy. A stack pointer placed just above zero and randomized request masks with changing program counters check address wrap and the capture of the return address.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PUSH = 2'd1,
        SEQ_LOAD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any    = |req;
    assign onehot = req & (~req + N'(1));

    always_comb begin
        // R2
        onehot_pick_chk: assert ($onehot0(onehot));
    end

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int N         = 8,
    parameter int PC_W      = 22,
    parameter int LONG_JUMP = 1,
    parameter int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             is_reset,
    input  logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  vec_pc
);

    localparam int VN_W = IDX_W + 1;

    logic [VN_W-1:0] vnum;

    assign vnum = is_reset ? '0 : (VN_W'(idx) + VN_W'(1));

    generate
        if (LONG_JUMP != 0) begin : g_two_word
            assign vec_pc = PC_W'(vnum) << 1;
        end else begin : g_one_word
            assign vec_pc = PC_W'(vnum);
        end
    endgenerate

endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux #(
    parameter int NBYTES = 3,
    parameter int CNT_W  = 2
) (
    input  logic [8*NBYTES-1:0] ret,
    input  logic [CNT_W-1:0]    sel,
    output logic [7:0]          byte_o
);

    logic [7:0] lanes [NBYTES];

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            assign lanes[g] = ret[8*g +: 8];
        end
    endgenerate

    always_comb begin
        byte_o = lanes[0];
        for (int k = 0; k < NBYTES; k++) begin
            if (sel == CNT_W'(k)) byte_o = lanes[k];
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int PC_W      = 22,
    parameter int PC_BYTES  = 3,
    parameter int LONG_JUMP = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               rst_req,
    input  logic               gie_in,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [15:0]        sp_in,
    output logic               busy,
    output logic               mem_we,
    output logic [15:0]        mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_out,
    output logic [15:0]        sp_out,
    output logic               gie_clr,
    output logic [NUM_SRC-1:0] pending
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int RET_W = 8 * PC_BYTES;
    localparam int CNT_W = $clog2(PC_BYTES + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [NUM_SRC-1:0] pend;
        logic               rst_pend;
        logic [RET_W-1:0]   ret;
        logic [15:0]        sp;
        logic [PC_W-1:0]    vec;
        logic [CNT_W-1:0]   cnt;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_SRC-1:0] pick_oh;
    logic [PC_W-1:0]    vec_pc_d;
    logic [NUM_SRC-1:0] clr_d;
    logic [7:0]         push_byte;

    irq_lowest_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req    (r_q.pend),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    irq_vec_map #(.N(NUM_SRC), .PC_W(PC_W), .LONG_JUMP(LONG_JUMP), .IDX_W(IDX_W)) u_vec (
        .is_reset (r_q.rst_pend),
        .idx      (pick_idx),
        .vec_pc   (vec_pc_d)
    );

    irq_push_mux #(.NBYTES(PC_BYTES), .CNT_W(CNT_W)) u_mux (
        .ret    (r_q.ret),
        .sel    (r_q.cnt),
        .byte_o (push_byte)
    );

    always_comb begin
        r_d   = r_q;
        clr_d = '0;
        case (r_q.st)
            SEQ_IDLE: begin
                if (gie_in && (r_q.rst_pend || pick_any)) begin
                    r_d.st  = SEQ_PUSH;
                    r_d.cnt = '0;
                    r_d.ret = RET_W'(pc_in);
                    r_d.sp  = sp_in;
                    r_d.vec = vec_pc_d;
                    if (r_q.rst_pend) r_d.rst_pend = 1'b0;
                    else              clr_d        = pick_oh;
                end
            end
            SEQ_PUSH: begin
                r_d.sp  = r_q.sp - 16'd1;
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == CNT_W'(PC_BYTES - 1)) r_d.st = SEQ_LOAD;
            end
            SEQ_LOAD: begin
                r_d.st = SEQ_IDLE;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
        r_d.pend     = (r_q.pend & ~clr_d) | hw_req;
        r_d.rst_pend = r_d.rst_pend | rst_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != SEQ_IDLE);
    assign mem_we    = (r_q.st == SEQ_PUSH);
    assign mem_addr  = r_q.sp;
    assign mem_wdata = push_byte;
    assign pc_load   = (r_q.st == SEQ_LOAD);
    assign gie_clr   = (r_q.st == SEQ_LOAD);
    assign pc_out    = r_q.vec;
    assign sp_out    = r_q.sp;
    assign pending   = r_q.pend;

    // R9
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R3
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gie_in));

    // R9
    load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R8
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(gie_clr));

    // R4
    rst_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(r_q.rst_pend)) |-> (pending == ($past(pending) | $past(hw_req))));

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_ref_model #(
    parameter int NUM_SRC   = 8,
    parameter int PC_W      = 22,
    parameter int PC_BYTES  = 3,
    parameter int LONG_JUMP = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               rst_req,
    input  logic               gie_in,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [15:0]        sp_in,
    input  logic               busy,
    input  logic               mem_we,
    input  logic [15:0]        mem_addr,
    input  logic [7:0]         mem_wdata,
    input  logic               pc_load,
    input  logic [PC_W-1:0]    pc_out,
    input  logic [15:0]        sp_out,
    input  logic               gie_clr,
    input  logic [NUM_SRC-1:0] pending,
    output int                 n_chk,
    output int                 n_bad
);
    logic [NUM_SRC-1:0] m_pend;
    bit                 m_rst;
    int                 phase;
    int                 vnum;
    longint             ret;
    int                 sp;

    initial begin
        n_chk = 0; n_bad = 0; m_pend = '0; m_rst = 0; phase = 0; vnum = 0; ret = 0; sp = 0;
    end

    task automatic cmp(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cfg%0d: actual %0h expected %0h at %0t", tag, PC_BYTES, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_rst = 0; phase = 0;
        end else begin
            logic [NUM_SRC-1:0] clr;
            clr = '0;
            if (phase == 0) begin
                if (gie_in && (m_rst || m_pend != 0)) begin
                    if (m_rst) begin
                        vnum = 0; m_rst = 0;
                    end else begin
                        int lo;
                        lo = -1;
                        for (int i = 0; i < NUM_SRC; i++)
                            if (lo < 0 && m_pend[i]) lo = i;
                        vnum = lo + 1;
                        clr[lo] = 1'b1;
                    end
                    ret = longint'(pc_in);
                    sp = sp_in;
                    phase = 1;
                end
            end else if (phase <= PC_BYTES) begin
                sp = (sp - 1) & 16'hFFFF;
                phase++;
            end else begin
                phase = 0;
            end
            m_pend = (m_pend & ~clr) | hw_req;
            if (rst_req) m_rst = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit ex_we, ex_ld;
            ex_we = (phase >= 1 && phase <= PC_BYTES);
            ex_ld = (phase == PC_BYTES + 1);
            cmp("R3 R9 R11 busy", busy, phase != 0);
            cmp("R6 R9 R11 mem_we", mem_we, ex_we);
            cmp("R9 R11 pc_load", pc_load, ex_ld);
            cmp("R8 R11 gie_clr", gie_clr, ex_ld);
            cmp("R2 R4 R10 R11 pending", pending, m_pend);
            if (ex_we) begin
                cmp("R6 mem_wdata", mem_wdata, (ret >> (8 * (phase - 1))) & 8'hFF);
                cmp("R7 mem_addr", mem_addr, sp);
            end
            if (ex_ld) begin
                longint epc;
                epc = (longint'(vnum) * ((LONG_JUMP != 0) ? 2 : 1)) & ((64'd1 << PC_W) - 1);
                cmp("R1 R4 R5 pc_out", pc_out, epc);
                cmp("R7 sp_out", sp_out, sp);
            end
        end
    end
endmodule

module irq_entry_seq_bench;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] hw_req = '0;
    logic          rst_req = 1'b0;
    logic          gie_in = 1'b0;
    logic [23:0]   pc_drv = '0;
    logic [15:0]   sp_in = 16'h08FF;
    bit            finished = 0;

    always #10 clk = ~clk;

    logic          a_busy, a_we, a_ld, a_gc;
    logic [15:0]   a_addr, a_sp;
    logic [7:0]    a_wd;
    logic [21:0]   a_pc;
    logic [NS-1:0] a_pend;
    int            a_chk, a_bad;

    logic          b_busy, b_we, b_ld, b_gc;
    logic [15:0]   b_addr, b_sp;
    logic [7:0]    b_wd;
    logic [15:0]   b_pc;
    logic [NS-1:0] b_pend;
    int            b_chk, b_bad;

    logic          c_busy, c_we, c_ld, c_gc;
    logic [15:0]   c_addr, c_sp;
    logic [7:0]    c_wd;
    logic [7:0]    c_pc;
    logic [NS-1:0] c_pend;
    int            c_chk, c_bad;

    irq_entry_seq #(.NUM_SRC(NS), .PC_W(22), .PC_BYTES(3), .LONG_JUMP(1)) u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[21:0]), .sp_in(sp_in), .busy(a_busy), .mem_we(a_we), .mem_addr(a_addr),
        .mem_wdata(a_wd), .pc_load(a_ld), .pc_out(a_pc), .sp_out(a_sp), .gie_clr(a_gc), .pending(a_pend));
    irq_ref_model #(.NUM_SRC(NS), .PC_W(22), .PC_BYTES(3), .LONG_JUMP(1)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[21:0]), .sp_in(sp_in), .busy(a_busy), .mem_we(a_we), .mem_addr(a_addr),
        .mem_wdata(a_wd), .pc_load(a_ld), .pc_out(a_pc), .sp_out(a_sp), .gie_clr(a_gc), .pending(a_pend),
        .n_chk(a_chk), .n_bad(a_bad));

    irq_entry_seq #(.NUM_SRC(NS), .PC_W(16), .PC_BYTES(2), .LONG_JUMP(0)) u_irq_entry_seq_b (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[15:0]), .sp_in(sp_in), .busy(b_busy), .mem_we(b_we), .mem_addr(b_addr),
        .mem_wdata(b_wd), .pc_load(b_ld), .pc_out(b_pc), .sp_out(b_sp), .gie_clr(b_gc), .pending(b_pend));
    irq_ref_model #(.NUM_SRC(NS), .PC_W(16), .PC_BYTES(2), .LONG_JUMP(0)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[15:0]), .sp_in(sp_in), .busy(b_busy), .mem_we(b_we), .mem_addr(b_addr),
        .mem_wdata(b_wd), .pc_load(b_ld), .pc_out(b_pc), .sp_out(b_sp), .gie_clr(b_gc), .pending(b_pend),
        .n_chk(b_chk), .n_bad(b_bad));

    irq_entry_seq #(.NUM_SRC(NS), .PC_W(8), .PC_BYTES(1), .LONG_JUMP(1)) u_irq_entry_seq_c (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[7:0]), .sp_in(sp_in), .busy(c_busy), .mem_we(c_we), .mem_addr(c_addr),
        .mem_wdata(c_wd), .pc_load(c_ld), .pc_out(c_pc), .sp_out(c_sp), .gie_clr(c_gc), .pending(c_pend));
    irq_ref_model #(.NUM_SRC(NS), .PC_W(8), .PC_BYTES(1), .LONG_JUMP(1)) u_ref_c (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .rst_req(rst_req), .gie_in(gie_in),
        .pc_in(pc_drv[7:0]), .sp_in(sp_in), .busy(c_busy), .mem_we(c_we), .mem_addr(c_addr),
        .mem_wdata(c_wd), .pc_load(c_ld), .pc_out(c_pc), .sp_out(c_sp), .gie_clr(c_gc), .pending(c_pend),
        .n_chk(c_chk), .n_bad(c_bad));

    int extra_chk = 0;
    int extra_bad = 0;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NS-1:0] hw, input logic rr);
        @(negedge clk);
        hw_req  = hw;
        rst_req = rr;
        @(negedge clk);
        hw_req  = '0;
        rst_req = 1'b0;
    endtask

    task automatic report;
        int t, f;
        t = a_chk + b_chk + c_chk + extra_chk;
        f = a_bad + b_bad + c_bad + extra_bad;
        $display("  [TB] %0d tests run, %0d failed", t, f);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state checked explicitly at release
        extra_chk++;
        if (a_busy || a_we || a_ld || a_gc || a_pend != 0) begin
            extra_bad++;
            $display("FAIL R11 reset state: actual busy=%0b pend=%0h expected 0 0", a_busy, a_pend);
        end
        rst_n = 1'b1;
        idle(2);

        // R3: requests held while enable is low
        gie_in = 1'b0;
        pulse(8'h28, 1'b0);
        idle(8);
        // R1 R2: lowest first, others stay; pc_in changes after accept
        pc_drv = 24'h12A5C3;
        sp_in  = 16'h08FF;
        gie_in = 1'b1;
        idle(2);
        pc_drv = 24'h3F0011;
        idle(20);

        // R10: requests during busy
        pulse(8'h01, 1'b0);
        idle(1);
        pulse(8'h80, 1'b0);
        idle(30);

        // R4: reset and hardware request together
        gie_in = 1'b0;
        pulse(8'h04, 1'b1);
        idle(2);
        pc_drv = 24'h00ABCD;
        gie_in = 1'b1;
        idle(30);

        // R7: stack pointer wrap
        sp_in  = 16'h0001;
        pc_drv = 24'hC0FFEE;
        pulse(8'h02, 1'b0);
        idle(15);

        // R1 R5 R6: all sources at once
        gie_in = 1'b0;
        sp_in  = 16'h0200;
        pulse(8'hFF, 1'b0);
        gie_in = 1'b1;
        idle(80);

        // randomized masks, reset requests and enable toggling
        for (int it = 0; it < 60; it++) begin
            pc_drv = 24'($urandom);
            sp_in  = 16'($urandom);
            gie_in = ($urandom % 4) != 0;
            pulse(NS'($urandom), ($urandom % 6) == 0);
            idle($urandom % 6);
        end
        gie_in = 1'b1;
        idle(120);

        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            extra_chk++;
            extra_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end
endmodule